// File: doc/BRIEF.md
# DDR2 Refresh and Power-Down Sequencer

This block keeps a DDR2 device refreshed and drives its clock-enable line. A free-running interval timer raises one refresh obligation per interval. The interval is the base value in the normal temperature range and half of it in the extended range. Each obligation is recorded in a saturating debt counter. While debt is owed, the sequencer asks the command scheduler for the bus. It waits until the scheduler has yielded and every bank reports idle, then issues REFRESH. After that it keeps the bus silent for the refresh cycle time. Several owed refreshes are issued back to back, one per refresh cycle time.

On a sleep request with no debt owed, the sequencer takes the bus the same way. It then issues the self-refresh entry command with clock enable low in the same cycle, and keeps clock enable low until a wake request arrives. On wake it raises clock enable at once. It holds the bus for a parameterised exit time with no commands, and only then hands the bus back. The interval timer restarts from a full interval on exit. Debt is discarded on entry, because the device refreshes itself while asleep.

Top module: `refresh_pm_seq`

## Requirements
- R1: During reset and in the first cycle after it, `cke_o` is 1, `cmd_o` is 2'b00 (NOP) and `own_req_o` is 0.
- R2: With the bus always granted and banks idle, successive REFRESH commands are exactly BASE_INTERVAL cycles apart when `hot_i` is 0 and BASE_INTERVAL/2 cycles apart when `hot_i` is 1. The value of `hot_i` is taken each time the timer expires.
- R3: While debt is owed, `own_req_o` is high. REFRESH (`cmd_o` = 2'b01) appears only in the cycle after `gnt_i` and `banks_idle_i` were both sampled high, and no command other than NOP leaves the block while `own_req_o` is low.
- R4: After a REFRESH that leaves no debt, `cmd_o` stays NOP and `own_req_o` falls exactly TRFC_CYC cycles after the REFRESH cycle. No two REFRESH commands are closer than TRFC_CYC cycles.
- R5: Owed refreshes are issued back to back, each exactly TRFC_CYC cycles after the previous one, without releasing the bus.
- R6: At most MAX_OWED refreshes can be owed. An expiry that occurs while MAX_OWED are already owed is lost.
- R7: A sleep request with no debt owed leads, once `gnt_i` and `banks_idle_i` are both sampled high, to one cycle where `cmd_o` is 2'b10 (self-refresh entry) and `cke_o` is 0. `cke_o` falls only in such a cycle.
- R8: While in self refresh, `cke_o` stays 0, `cmd_o` stays NOP, `own_req_o` stays high, and no refresh debt accumulates.
- R9: A wake request sampled in self refresh makes `cke_o` 1 in the next cycle. `own_req_o` is then held high for XSR_CYC cycles and falls in the following one. The first refresh after exit comes a full interval later.
- R10: When debt is owed and sleep is requested at the same time, the owed REFRESH is issued before the self-refresh entry.
- R11: If the sleep request is withdrawn before the bus is granted, the sequencer releases `own_req_o` in the next cycle and `cke_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | 1 = extended temperature range (half interval) |
| gnt_i | input | 1 | Scheduler has yielded the command bus |
| banks_idle_i | input | 1 | All banks are precharged |
| sleep_req_i | input | 1 | Request to enter self refresh |
| wake_req_i | input | 1 | Request to leave self refresh |
| own_req_o | output | 1 | Sequencer wants or holds the command bus |
| cmd_o | output | 2 | 00 NOP, 01 REFRESH, 10 self-refresh entry |
| cke_o | output | 1 | Clock enable to the device |

## Verification
The bench builds the block with a 64-cycle base interval, a 6-cycle refresh cycle time, an 8-deep debt limit and a 5-cycle exit time. This brings interval halving, debt saturation and full back-to-back bursts within a few hundred cycles. With these values a burst of eight refreshes (48 cycles) fits between two expiries, so the bench can tell a burst cut at the limit from one stretched by a later expiry. Holding the grant low across nine expiries shows that the ninth is lost.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_REF = 2'd1,
    CMD_SRE = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_REF,
    ST_REF,
    ST_TRFC,
    ST_REQ_SR,
    ST_SRE,
    ST_SR,
    ST_WAKE
  } st_e;

  // refresh interval for the current temperature range
  function automatic int unsigned rps_interval(int unsigned base, logic hot);
    return hot ? (base / 2) : base;
  endfunction

  // saturating up/down step for the refresh debt
  function automatic int unsigned rps_owed_step(int unsigned cur, int unsigned cap,
                                                logic up, logic dn);
    if (up && !dn)
      return (cur < cap) ? cur + 1 : cur;
    if (dn && !up)
      return (cur > 0) ? cur - 1 : 0;
    return cur;
  endfunction

endpackage

// File: rtl/rps_tick_gen.sv
module rps_tick_gen
  import rps_pkg::*;
#(
  parameter int unsigned BASE_INTERVAL = 2080
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(BASE_INTERVAL + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload;

  assign reload = CW'(rps_interval(BASE_INTERVAL, hot_i) - 1);
  assign tick_o = (cnt_q == '0) && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= CW'(BASE_INTERVAL - 1);
    else if (restart_i || cnt_q == '0)
      cnt_q <= reload;
    else
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rps_owed_ctr.sv
module rps_owed_ctr
  import rps_pkg::*;
#(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          clr_i,
  output logic [OW-1:0] owed_o,
  output logic          pending_o
);
  logic [OW-1:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)
      owed_q <= '0;
    else
      owed_q <= OW'(rps_owed_step(int'(owed_q), MAX_OWED, inc_i, dec_i));
  end

  assign owed_o    = owed_q;
  assign pending_o = (owed_q != '0);
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
  import rps_pkg::*;
#(
  parameter int unsigned TRFC_CYC = 28,
  parameter int unsigned XSR_CYC  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pending_i,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       gnt_i,
  input  logic       banks_idle_i,
  output logic [1:0] cmd_o,
  output logic       cke_o,
  output logic       own_req_o,
  output logic       ref_issue_o,
  output logic       sr_active_o,
  output logic       in_sr_o
);
  localparam int unsigned TMAX = (TRFC_CYC > XSR_CYC) ? TRFC_CYC : XSR_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  st_e           st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          bus_ready;

  assign bus_ready = gnt_i && banks_idle_i;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    case (st_q)
      ST_IDLE: begin
        if (pending_i)        st_d = ST_REQ_REF;
        else if (sleep_req_i) st_d = ST_REQ_SR;
      end
      ST_REQ_REF: if (bus_ready) st_d = ST_REF;
      ST_REF: begin
        st_d  = ST_TRFC;
        tmr_d = TW'(TRFC_CYC - 2);
      end
      ST_TRFC: begin
        if (tmr_q == '0) st_d = pending_i ? ST_REF : ST_IDLE;
        else             tmr_d = tmr_q - 1'b1;
      end
      ST_REQ_SR: begin
        if (!sleep_req_i)   st_d = ST_IDLE;
        else if (bus_ready) st_d = ST_SRE;
      end
      ST_SRE: st_d = ST_SR;
      ST_SR: begin
        if (wake_req_i) begin
          st_d  = ST_WAKE;
          tmr_d = TW'(XSR_CYC - 1);
        end
      end
      ST_WAKE: begin
        if (tmr_q == '0) st_d = ST_IDLE;
        else             tmr_d = tmr_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign ref_issue_o = (st_q == ST_REF);
  assign in_sr_o     = (st_q == ST_SR);
  assign sr_active_o = (st_q == ST_SRE) || (st_q == ST_SR) || (st_q == ST_WAKE);
  assign cke_o       = !((st_q == ST_SRE) || (st_q == ST_SR));
  assign own_req_o   = (st_q != ST_IDLE);
  assign cmd_o       = (st_q == ST_REF) ? CMD_REF :
                       (st_q == ST_SRE) ? CMD_SRE : CMD_NOP;
endmodule

// File: rtl/refresh_pm_seq.sv
module refresh_pm_seq
  import rps_pkg::*;
#(
  parameter int unsigned BASE_INTERVAL = 2080,
  parameter int unsigned TRFC_CYC      = 28,
  parameter int unsigned MAX_OWED      = 8,
  parameter int unsigned XSR_CYC       = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hot_i,
  input  logic       gnt_i,
  input  logic       banks_idle_i,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  output logic       own_req_o,
  output logic [1:0] cmd_o,
  output logic       cke_o
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);

  // named internal events, visible to the bound checker
  logic          tick;
  logic          ref_issue;
  logic          sr_active;
  logic          in_sr;
  logic          pending;
  logic [OW-1:0] owed;

  rps_tick_gen #(.BASE_INTERVAL(BASE_INTERVAL)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot_i     (hot_i),
    .restart_i (sr_active),
    .tick_o    (tick)
  );

  rps_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (tick),
    .dec_i     (ref_issue),
    .clr_i     (sr_active),
    .owed_o    (owed),
    .pending_o (pending)
  );

  rps_fsm #(.TRFC_CYC(TRFC_CYC), .XSR_CYC(XSR_CYC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pending_i    (pending),
    .sleep_req_i  (sleep_req_i),
    .wake_req_i   (wake_req_i),
    .gnt_i        (gnt_i),
    .banks_idle_i (banks_idle_i),
    .cmd_o        (cmd_o),
    .cke_o        (cke_o),
    .own_req_o    (own_req_o),
    .ref_issue_o  (ref_issue),
    .sr_active_o  (sr_active),
    .in_sr_o      (in_sr)
  );
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int unsigned TRFC_CYC = 28,
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1),
  localparam int unsigned SW = $clog2(TRFC_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cmd_o,
  input logic          cke_o,
  input logic          own_req_o,
  input logic          gnt_i,
  input logic          banks_idle_i,
  input logic          wake_req_i,
  input logic          in_sr,
  input logic [OW-1:0] owed
);
  // cycles since the last REFRESH, saturating at TRFC_CYC
  logic [SW-1:0] since_ref;

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_ref <= SW'(TRFC_CYC);
    else if (cmd_o == 2'd1)
      since_ref <= SW'(1);
    else if (since_ref < SW'(TRFC_CYC))
      since_ref <= since_ref + 1'b1;
  end

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd1) |-> (since_ref >= SW'(TRFC_CYC))); // R4

  AST_CMD_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 2'd0) |-> own_req_o); // R3

  AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED)); // R6

  AST_CKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> ($past(gnt_i && banks_idle_i) && cmd_o == 2'd2)); // R7

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_o && !$fell(cke_o)) |-> (cmd_o == 2'd0 && own_req_o)); // R8

  AST_WAKE_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && wake_req_i) |=> cke_o); // R9
endmodule

bind refresh_pm_seq rps_checker #(.TRFC_CYC(TRFC_CYC), .MAX_OWED(MAX_OWED)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_o        (cmd_o),
  .cke_o        (cke_o),
  .own_req_o    (own_req_o),
  .gnt_i        (gnt_i),
  .banks_idle_i (banks_idle_i),
  .wake_req_i   (wake_req_i),
  .in_sr        (in_sr),
  .owed         (owed)
);

// File: tb/tb_refresh_pm_seq.sv
module tb_refresh_pm_seq;
  localparam int CLK_PERIOD = 10;
  localparam int INTV  = 64;
  localparam int TRFC  = 6;
  localparam int MAXO  = 8;
  localparam int XSR   = 5;
  localparam int NVEC  = 4;

  // vector table: temperature range and expected REFRESH spacing
  localparam logic VHOT [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int   VGAP [NVEC] = '{INTV, INTV - INTV / 2, INTV, INTV >> 1};

  logic       clk = 1'b0;
  logic       rst_n, hot_i, gnt_i, banks_idle_i, sleep_req_i, wake_req_i;
  logic       own_req_o, cke_o;
  logic [1:0] cmd_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refresh_pm_seq #(
    .BASE_INTERVAL(INTV), .TRFC_CYC(TRFC), .MAX_OWED(MAXO), .XSR_CYC(XSR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .gnt_i(gnt_i),
    .banks_idle_i(banks_idle_i), .sleep_req_i(sleep_req_i), .wake_req_i(wake_req_i),
    .own_req_o(own_req_o), .cmd_o(cmd_o), .cke_o(cke_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance negedges until a non-NOP command shows; n = negedges advanced
  task automatic wait_cmd(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (cmd_o != 2'd0) break;
    end
  endtask

  // advance negedges while own_req_o is high; k = negedges advanced
  task automatic wait_release(output int k, output int cmds);
    k = 0;
    cmds = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      k++;
      if (!own_req_o) break;
      if (cmd_o != 2'd0) cmds++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, k, c, cnt, bad;
    rst_n = 1'b0; hot_i = 1'b0; gnt_i = 1'b1; banks_idle_i = 1'b1;
    sleep_req_i = 1'b0; wake_req_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cke in reset", int'(cke_o), 1);
    chk("R1 cmd in reset", int'(cmd_o), 0);
    chk("R1 own_req in reset", int'(own_req_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 own_req after reset", int'(own_req_o), 0);

    // vector walk: spacing per temperature range and release after tRFC
    for (int v = 0; v < NVEC; v++) begin
      hot_i = VHOT[v];
      wait_cmd(n);
      wait_cmd(n);
      chk("R2 command is REFRESH", int'(cmd_o), 1);
      wait_release(k, c);
      chk("R4 release after REFRESH", k, TRFC);
      chk("R4 quiet during tRFC", c, 0);
      wait_cmd(n);
      chk("R2 refresh spacing", k + n, VGAP[v]);
    end
    hot_i = 1'b0;

    // R3: refresh waits for grant and idle banks
    wait_cmd(n);
    wait_release(k, c);
    gnt_i = 1'b0;
    for (int i = 0; i < 200 && !own_req_o; i++) @(negedge clk);
    chk("R3 own_req raised by debt", int'(own_req_o), 1);
    cnt = 0;
    repeat (8) begin @(negedge clk); if (cmd_o != 2'd0) cnt++; end
    chk("R3 no command without grant", cnt, 0);
    gnt_i = 1'b1; banks_idle_i = 1'b0;
    cnt = 0;
    repeat (5) begin @(negedge clk); if (cmd_o != 2'd0) cnt++; end
    chk("R3 no command with busy banks", cnt, 0);
    banks_idle_i = 1'b1;
    @(negedge clk);
    chk("R3 REFRESH one cycle after ready", int'(cmd_o), 1);

    // R5/R6: nine expiries with the bus withheld, then a burst
    wait_cmd(n);
    wait_release(k, c);
    gnt_i = 1'b0;
    repeat (580 - TRFC) @(negedge clk);
    gnt_i = 1'b1;
    wait_cmd(n);
    chk("R5 burst starts next cycle", n, 1);
    cnt = 1; bad = 0;
    for (int i = 0; i < 20; i++) begin
      k = 0;
      do begin @(negedge clk); k++; end while (own_req_o && cmd_o == 2'd0);
      if (cmd_o != 2'd1) break;
      cnt++;
      if (k != TRFC) bad++;
    end
    chk("R6 burst length capped", cnt, MAXO);
    chk("R5 back-to-back spacing errors", bad, 0);

    // R10/R7: debt and sleep together
    gnt_i = 1'b0;
    for (int i = 0; i < 200 && !own_req_o; i++) @(negedge clk);
    sleep_req_i = 1'b1;
    repeat (2) @(negedge clk);
    gnt_i = 1'b1;
    wait_cmd(n);
    chk("R10 refresh before sleep", int'(cmd_o), 1);
    wait_cmd(n);
    chk("R7 self-refresh entry command", int'(cmd_o), 2);
    chk("R7 cke low with entry", int'(cke_o), 0);

    // R8: quiet self refresh
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (cke_o || cmd_o != 2'd0 || !own_req_o) bad++;
    end
    chk("R8 self-refresh violations", bad, 0);

    // R9: wake
    wake_req_i = 1'b1; sleep_req_i = 1'b0;
    @(negedge clk);
    chk("R9 cke high after wake", int'(cke_o), 1);
    wake_req_i = 1'b0;
    repeat (XSR - 1) @(negedge clk);
    chk("R9 bus held through exit time", int'(own_req_o), 1);
    @(negedge clk);
    chk("R9 bus released after exit time", int'(own_req_o), 0);
    wait_cmd(n);
    chk("R9 first refresh after exit", n, INTV + 2);

    // R11: withdrawn sleep request
    wait_release(k, c);
    gnt_i = 1'b0; sleep_req_i = 1'b1;
    @(negedge clk);
    chk("R11 own_req for sleep", int'(own_req_o), 1);
    sleep_req_i = 1'b0;
    @(negedge clk);
    chk("R11 own_req released", int'(own_req_o), 0);
    chk("R11 cke stays high", int'(cke_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule